// File: doc/BRIEF.md
# Coprocessor Register Transfer Unit

This unit links a 32-bit integer core to as many as sixteen optional coprocessors for single-word register moves in either direction. The core offers one instruction word, the value of its source register and the result of its own condition test. The unit decodes the word and checks that it is a register transfer. It then puts the target unit number and the opcode and register fields on a shared request bus. It waits a fixed number of cycles for the addressed unit to claim the request.

When the claim comes, the unit finishes the move. A write completes with a done pulse. A read writes the returned word into the core's register file. If the destination register is 15, only the top nibble of the returned word is kept, and it becomes the core's new N, Z, C, V flags. When no claim arrives inside the window, the unit gives an undefined-instruction trap pulse and moves no data.

Top module: `cp_xfer_if`

## Requirements
- R1: A word counts as a register transfer only when bits[27:24] are 4'b1110 and bit[4] is 1. Any other offered word starts no request and gives no done, trap, register write or flag update.
- R2: A transfer runs when cond_pass is 1 or when bits[31:28] are 4'b1111 (the unconditional extended form, which runs whatever cond_pass is). A transfer with bits[31:28] other than 4'b1111 and cond_pass at 0 gives no request, no data movement and no trap.
- R3: From the first cycle after an accepted issue until the transfer ends, cp_req is 1 and the bus holds fixed values taken from the issued word: cp_num is bits[11:8], cp_op1 is bits[23:21], cp_crn is bits[19:16], cp_crm is bits[3:0], cp_op2 is bits[7:5], cp_dir is bit[20] (1 for a read from the coprocessor), and cp_wdata is the core_wdata value captured at issue.
- R4: Only cp_accept[cp_num] counts as a claim. An accept from any other unit is ignored.
- R5: If no claim is sampled on the first ACC_WIN clock edges after the issue edge, undef_trap pulses for one cycle. The pulse appears ACC_WIN+1 cycles after the issue edge.
- R6: A claim sampled on the k-th edge after the issue edge (k from 1 to ACC_WIN) ends the transfer. done pulses one cycle after that edge.
- R7: For a claimed read whose destination (bits[15:12]) is not 15, rf_we pulses together with done. At that moment rf_waddr holds the destination and rf_wdata holds the full 32-bit cp_rdata sampled with the claim.
- R8: For a claimed read whose destination is 15, flag_we pulses together with done and flags_nzcv holds cp_rdata[31:28]. rf_we stays 0.
- R9: rf_we and flag_we are never both 1, and each lasts exactly one cycle. A claimed write raises neither of them.
- R10: While busy is 1, issue is ignored.
- R11: After reset, busy, cp_req, done, undef_trap, rf_we and flag_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction word offered this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Core condition test result |
| core_wdata | input | 32 | Source register value for a write |
| busy | output | 1 | Transfer in progress |
| cp_req | output | 1 | Request broadcast to the coprocessors |
| cp_num | output | 4 | Target coprocessor number |
| cp_op1 | output | 3 | First opcode field |
| cp_op2 | output | 3 | Second opcode field |
| cp_crn | output | 4 | Primary coprocessor register |
| cp_crm | output | 4 | Secondary coprocessor register |
| cp_dir | output | 1 | 1 read from coprocessor, 0 write to it |
| cp_wdata | output | 32 | Data sent to the coprocessor |
| cp_accept | input | 16 | Per-unit claim lines |
| cp_rdata | input | 32 | Data returned by the coprocessor |
| done | output | 1 | Transfer completed pulse |
| undef_trap | output | 1 | No-claim trap pulse |
| rf_we | output | 1 | Register file write pulse |
| rf_waddr | output | 4 | Register file destination |
| rf_wdata | output | 32 | Register file write data |
| flag_we | output | 1 | Condition flag update pulse |
| flags_nzcv | output | 4 | New N, Z, C, V flags |

## Verification
Counting from the negative edge at which issue is driven, the request bus is due one cycle later. A claim presented in cycle c (counted the same way) produces its completion pulses in cycle c+1. A missing claim produces the trap in cycle ACC_WIN+1. For every instruction, the bench notes the first cycle in which any result pulse shows and compares that cycle number with the due cycle. It also checks the kind of pulse and the data that comes with it. The cycle after each pulse is checked for silence. For transfers that must not run, the bench watches eight cycles and expects no request and no pulse at all.

// File: rtl/cp_xfer_if.sv
module cp_xfer_if #(
  parameter int ACC_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [31:0] instr,
  input  logic        cond_pass,
  input  logic [31:0] core_wdata,
  output logic        busy,
  output logic        cp_req,
  output logic [3:0]  cp_num,
  output logic [2:0]  cp_op1,
  output logic [2:0]  cp_op2,
  output logic [3:0]  cp_crn,
  output logic [3:0]  cp_crm,
  output logic        cp_dir,
  output logic [31:0] cp_wdata,
  input  logic [15:0] cp_accept,
  input  logic [31:0] cp_rdata,
  output logic        done,
  output logic        undef_trap,
  output logic        rf_we,
  output logic [3:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        flag_we,
  output logic [3:0]  flags_nzcv
);
  localparam int CW = $clog2(ACC_WIN + 1);

  logic [31:0] ir;
  logic [CW-1:0] cnt;
  logic is_xfer, run_ok, go, hit, expire;

  assign is_xfer = (instr[27:24] == 4'b1110) && instr[4];
  assign run_ok  = (instr[31:28] == 4'b1111) || cond_pass;
  assign go      = issue && !busy && is_xfer && run_ok;
  assign hit     = busy && cp_accept[ir[11:8]];
  assign expire  = busy && !hit && (cnt == CW'(ACC_WIN - 1));

  assign cp_req   = busy;
  assign cp_num   = ir[11:8];
  assign cp_op1   = ir[23:21];
  assign cp_op2   = ir[7:5];
  assign cp_crn   = ir[19:16];
  assign cp_crm   = ir[3:0];
  assign cp_dir   = ir[20];
  assign rf_waddr = ir[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ir         <= '0;
      cnt        <= '0;
      cp_wdata   <= '0;
      done       <= 1'b0;
      undef_trap <= 1'b0;
      rf_we      <= 1'b0;
      rf_wdata   <= '0;
      flag_we    <= 1'b0;
      flags_nzcv <= '0;
    end else begin
      done       <= 1'b0;
      undef_trap <= 1'b0;
      rf_we      <= 1'b0;
      flag_we    <= 1'b0;
      if (go) begin
        busy     <= 1'b1;
        ir       <= instr;
        cp_wdata <= core_wdata;
        cnt      <= '0;
      end else if (hit) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (ir[20]) begin
          if (ir[15:12] == 4'd15) begin
            flag_we    <= 1'b1;
            flags_nzcv <= cp_rdata[31:28];
          end else begin
            rf_we    <= 1'b1;
            rf_wdata <= cp_rdata;
          end
        end
      end else if (expire) begin
        busy       <= 1'b0;
        undef_trap <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(rf_we && flag_we));
  p_rf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we);
  p_fl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) flag_we |=> !flag_we);
  p_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !busy && instr[31:28] != 4'b1111 && !cond_pass) |=> !cp_req);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && $past(cp_req)) |-> ($stable(cp_num) && $stable(cp_dir) && $stable(cp_wdata)));
  p_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    undef_trap |-> ($past(cp_req) && !cp_req && !done));
  p_flagonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (done && rf_waddr == 4'd15));
endmodule

// File: tb/cp_xfer_if_tb.sv
`timescale 1ns/1ps
module cp_xfer_if_tb;
  localparam int ACC_WIN = 4;
  localparam logic [2:0] K_NONE = 3'd0, K_WR = 3'd1, K_RF = 3'd2, K_FL = 3'd3, K_TRAP = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0, issue = 1'b0, cond_pass = 1'b0;
  logic [31:0] instr = '0, core_wdata = '0, cp_rdata = '0;
  logic [15:0] cp_accept = '0;
  logic busy, cp_req, cp_dir, done, undef_trap, rf_we, flag_we;
  logic [3:0] cp_num, cp_crn, cp_crm, rf_waddr, flags_nzcv;
  logic [2:0] cp_op1, cp_op2;
  logic [31:0] cp_wdata, rf_wdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cp_xfer_if #(.ACC_WIN(ACC_WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .cond_pass(cond_pass),
    .core_wdata(core_wdata), .busy(busy), .cp_req(cp_req), .cp_num(cp_num),
    .cp_op1(cp_op1), .cp_op2(cp_op2), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_dir(cp_dir),
    .cp_wdata(cp_wdata), .cp_accept(cp_accept), .cp_rdata(cp_rdata), .done(done),
    .undef_trap(undef_trap), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .flag_we(flag_we), .flags_nzcv(flags_nzcv));

  function automatic logic [31:0] mk(input logic [3:0] cnd, input logic [2:0] o1, input logic l,
      input logic [3:0] crn, input logic [3:0] rd, input logic [3:0] cp, input logic [2:0] o2,
      input logic [3:0] crm);
    return {cnd, 4'b1110, o1, l, crn, rd, cp, o2, 1'b1, crm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic        cpass;
    logic [31:0] wd;
    logic [3:0]  lat;
    logic [3:0]  unit;
    logic [31:0] resp;
    logic [2:0]  kind;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t V [NV] = '{
    '{mk(4'hE,3'd1,1'b0,4'd2,4'd4,4'd5,3'd3,4'd7), 1'b1, 32'hDEAD_BEEF, 4'd0, 4'd5, 32'h0, K_WR},
    '{mk(4'hE,3'd6,1'b0,4'd9,4'd1,4'd5,3'd0,4'd3), 1'b1, 32'h0123_4567, 4'd3, 4'd5, 32'h0, K_WR},
    '{mk(4'hE,3'd0,1'b1,4'd1,4'd3,4'd5,3'd2,4'd0), 1'b1, 32'h0, 4'd1, 4'd5, 32'hA5A5_1234, K_RF},
    '{mk(4'hE,3'd2,1'b1,4'd4,4'd15,4'd5,3'd1,4'd8), 1'b1, 32'h0, 4'd2, 4'd5, 32'h9FFF_FFFF, K_FL},
    '{mk(4'h0,3'd7,1'b1,4'd0,4'd15,4'd5,3'd7,4'd15), 1'b1, 32'h0, 4'd0, 4'd5, 32'h6000_0001, K_FL},
    '{mk(4'hE,3'd0,1'b0,4'd0,4'd2,4'd5,3'd0,4'd0), 1'b1, 32'h1111_1111, 4'd15, 4'd5, 32'h0, K_TRAP},
    '{mk(4'hE,3'd0,1'b1,4'd0,4'd2,4'd5,3'd0,4'd0), 1'b1, 32'h0, 4'd0, 4'd6, 32'hFFFF_FFFF, K_TRAP},
    '{mk(4'h0,3'd0,1'b1,4'd0,4'd2,4'd5,3'd0,4'd0), 1'b0, 32'h0, 4'd0, 4'd5, 32'h1234_5678, K_NONE},
    '{mk(4'hF,3'd5,1'b1,4'd3,4'd7,4'd15,3'd4,4'd2), 1'b0, 32'h0, 4'd2, 4'd15, 32'h8765_4321, K_RF},
    '{mk(4'hE,3'd0,1'b1,4'd0,4'd2,4'd5,3'd0,4'd0) & ~32'h10, 1'b1, 32'h0, 4'd0, 4'd5, 32'h5, K_NONE},
    '{mk(4'h1,3'd3,1'b0,4'd5,4'd0,4'd0,3'd6,4'd9), 1'b1, 32'hCAFE_F00D, 4'd0, 4'd0, 32'h0, K_WR}
  };

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int idx);
    int ev = 0;
    logic [2:0] got = K_NONE;
    logic [31:0] gdata = '0;
    logic [3:0] gaddr = '0;
    int expc;
    @(negedge clk);
    instr = v.ins; cond_pass = v.cpass; core_wdata = v.wd; issue = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      issue = 1'b0; cp_accept = '0;
      if (k == 1) begin
        if (v.kind == K_NONE)
          chk(!cp_req, "R1/R2", $sformatf("vec%0d no request", idx), 32'(cp_req), 32'd0);
        else
          chk(cp_req && cp_num == v.ins[11:8] && cp_dir == v.ins[20] && cp_wdata == v.wd &&
              cp_op1 == v.ins[23:21] && cp_op2 == v.ins[7:5] && cp_crn == v.ins[19:16] &&
              cp_crm == v.ins[3:0], "R3", $sformatf("vec%0d bus fields", idx),
              {cp_op1, cp_op2, cp_crn, cp_crm, cp_num, cp_dir, 7'd0, cp_req},
              {v.ins[23:21], v.ins[7:5], v.ins[19:16], v.ins[3:0], v.ins[11:8], v.ins[20], 8'd1});
      end
      if (ev != 0 && k == ev + 1)
        chk(!(done || rf_we || flag_we || undef_trap), "R9", $sformatf("vec%0d one-cycle pulse", idx),
            {28'd0, done, rf_we, flag_we, undef_trap}, 32'd0);
      if (ev == 0 && (done || undef_trap || rf_we || flag_we)) begin
        ev = k;
        got = undef_trap ? K_TRAP : flag_we ? K_FL : rf_we ? K_RF : K_WR;
        gdata = flag_we ? {28'd0, flags_nzcv} : rf_wdata;
        gaddr = rf_waddr;
      end
      if (v.lat != 4'd15 && k == int'(v.lat) + 1) begin
        cp_accept[v.unit] = 1'b1;
        cp_rdata = v.resp;
      end
    end
    cp_accept = '0;
    expc = (v.kind == K_NONE) ? 0 : (v.kind == K_TRAP) ? ACC_WIN + 1 : int'(v.lat) + 2;
    chk(ev == expc && got == v.kind, "R4/R5/R6", $sformatf("vec%0d result cycle/kind", idx),
        {ev[15:0], 13'd0, got}, {expc[15:0], 13'd0, v.kind});
    if (v.kind == K_RF)
      chk(gdata == v.resp && gaddr == v.ins[15:12], "R7", $sformatf("vec%0d rf data", idx),
          gdata, v.resp);
    if (v.kind == K_FL)
      chk(gdata == {28'd0, v.resp[31:28]}, "R8", $sformatf("vec%0d flags", idx),
          gdata, {28'd0, v.resp[31:28]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cp_req && !done && !undef_trap && !rf_we && !flag_we, "R11", "reset outputs",
        {26'd0, busy, cp_req, done, undef_trap, rf_we, flag_we}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run(V[i], i);

    // R10: issue held high while busy starts nothing new
    @(negedge clk);
    instr = mk(4'hE, 3'd0, 1'b0, 4'd0, 4'd0, 4'd5, 3'd0, 4'd0); cond_pass = 1'b1;
    core_wdata = 32'h5555_AAAA; issue = 1'b1;
    @(negedge clk);
    instr = mk(4'hE, 3'd0, 1'b1, 4'd0, 4'd2, 4'd9, 3'd0, 4'd0); core_wdata = 32'h0;
    @(negedge clk);
    chk(cp_num == 4'd5 && cp_wdata == 32'h5555_AAAA && !cp_dir, "R10", "busy ignores issue",
        {27'd0, cp_dir, cp_num}, 32'd5);
    @(negedge clk);
    issue = 1'b0; cp_accept[5] = 1'b1;
    @(negedge clk);
    cp_accept = '0;
    chk(done && !rf_we, "R6", "held-issue write done", {30'd0, done, rf_we}, 32'd2);
    @(negedge clk);
    chk(!cp_req, "R10", "no second request", 32'(cp_req), 32'd0);
    @(negedge clk);
    chk(!cp_req && !done, "R10", "still idle", {30'd0, cp_req, done}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule